// File: doc/BRIEF.md
# ADC Result Word Serializer

This block is the output half of a converter's four-wire serial port. A finished conversion delivers a 12-bit magnitude and a sign bit, together with the output format that the instruction logic chose. The block holds all of this in a shadow register. It then shifts the word out on the serial data line while the chip select input is low.

The format has four settings. Resolution is 8 or 12 magnitude bits. The word is either the bare resolution width or a padded 16 bits, with one more bit when the sign is included. The sign is either included or left out, and the bit order is MSB-first or LSB-first. Padding bits are sign copies when the sign is on and zeros when it is off. They go ahead of the magnitude in MSB-first order and after it in LSB-first order.

The chip select and serial clock pins are sampled on the system clock `clk`. The chip select falling edge places the first bit on the line without any serial clock edge. Each later falling serial clock edge moves to the next bit. Raising chip select abandons the word and releases the line.

Top module: `adc_result_shifter`

## Requirements
- R1: While reset is held, and directly after it, `sdo_oe` is 0 and `sdo` is 0.
- R2: On a clock where `res_load` is 1 and `cs_n` is 1, the block captures `res_mag`, `res_sign` and the four `cfg_*` inputs. That captured set governs every later word until the next capture.
- R3: The magnitude is `res_mag[11:0]` when `cfg_full`=1, and `res_mag[11:4]` when `cfg_full`=0. The word length is (16 if `cfg_wide`=1, else the magnitude width) plus 1 if `cfg_sign_en`=1. The possible lengths are 8, 9, 12, 13, 16 and 17.
- R4: With `cfg_lsb_first`=0, the padding bits come first, then the magnitude MSB down to LSB. A padding bit is `res_sign` when `cfg_sign_en`=1 and 0 otherwise.
- R5: With `cfg_lsb_first`=1, the magnitude goes out LSB up to MSB, followed by the padding bits defined in R4.
- R6: One clock after `cs_n` is sampled going from 1 to 0, `sdo_oe` is 1 and `sdo` carries the first word bit.
- R7: While `cs_n` stays low, `sdo` changes only in the clock after a sampled 1-to-0 transition of `sclk`. Each such transition presents the next word bit.
- R8: Once the last word bit has been shifted past, `sdo` is 0 for every further `sclk` fall until `cs_n` rises.
- R9: One clock after `cs_n` is sampled high, `sdo_oe` is 0 and `sdo` is 0. The next `cs_n` fall starts again from the first bit, even if the previous word was cut short.
- R10: `res_load` while `cs_n` is low has no effect. The word in progress continues with the previously captured data and format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; its falling edge advances the word |
| res_load | input | 1 | Strobe marking a finished conversion result |
| res_mag | input | 12 | Conversion magnitude |
| res_sign | input | 1 | Conversion sign |
| cfg_full | input | 1 | 1 = 12-bit resolution, 0 = 8-bit |
| cfg_wide | input | 1 | 1 = pad the word to 16 bits before the sign |
| cfg_sign_en | input | 1 | 1 = include the sign (as padding copies) |
| cfg_lsb_first | input | 1 | 1 = LSB-first order |
| sdo | output | 1 | Serial data; 0 while not driven |
| sdo_oe | output | 1 | Output enable for the data pad |

## Verification
The assertions assume that `cs_n` and `sclk` are already synchronous to `clk`. They also assume that every level on those pins lasts at least one clock, so that each edge is seen exactly once. The bench drives both pins on the falling edge of `clk` and holds each level for whole clocks, so the sampled edges match the intended ones. It also loads new results only while chip select is high, except in the one deliberate test of an ignored load.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef struct packed {
        logic full;
        logic wide;
        logic sgn_en;
        logic lsb;
    } ser_cfg_t;

endpackage

// File: rtl/adc_ser_edge.sv
module adc_ser_edge #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= RST_LVL;
        else        lvl_q <= din;
    end

    assign fall = lvl_q & ~din;
endmodule

// File: rtl/adc_ser_bitsel.sv
module adc_ser_bitsel
    import adc_ser_pkg::*;
#(
    parameter int MAG_W  = 12,
    parameter int LOW_W  = 8,
    parameter int WIDE_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic [MAG_W-1:0] mag,
    input  logic             sgn,
    input  ser_cfg_t         cfg,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o,
    output logic [IDX_W-1:0] total
);
    localparam int MIDX_W = $clog2(MAG_W);

    int   w;
    int   tot;
    int   ext;
    int   k;
    logic fill;
    logic [MIDX_W-1:0] pos;

    always_comb begin
        w     = cfg.full ? MAG_W : LOW_W;
        tot   = (cfg.wide ? WIDE_W : w) + (cfg.sgn_en ? 1 : 0);
        ext   = tot - w;
        k     = int'(idx);
        fill  = cfg.sgn_en & sgn;
        pos   = '0;
        bit_o = 1'b0;
        if (k < tot) begin
            if (!cfg.lsb) begin
                if (k < ext) begin
                    bit_o = fill;
                end else begin
                    pos   = MIDX_W'(MAG_W - 1 - (k - ext));
                    bit_o = mag[pos];
                end
            end else begin
                if (k < w) begin
                    pos   = MIDX_W'((MAG_W - w) + k);
                    bit_o = mag[pos];
                end else begin
                    bit_o = fill;
                end
            end
        end
        total = IDX_W'(tot);
    end
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
    import adc_ser_pkg::*;
#(
    parameter int MAG_W  = 12,
    parameter int LOW_W  = 8,
    parameter int WIDE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             res_load,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             res_sign,
    input  logic             cfg_full,
    input  logic             cfg_wide,
    input  logic             cfg_sign_en,
    input  logic             cfg_lsb_first,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int IDX_W = $clog2(WIDE_W + 3);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             dout;
        logic             oe;
        logic [MAG_W-1:0] mag;
        logic             sgn;
        ser_cfg_t         cfg;
    } shf_state_t;

    shf_state_t st_d, st_q;

    logic             cs_fall;
    logic             sclk_fall;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_bit;
    logic [IDX_W-1:0] word_len;

    adc_ser_edge #(.RST_LVL(1'b1)) u_cs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cs_n),
        .fall (cs_fall)
    );

    adc_ser_edge #(.RST_LVL(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sclk),
        .fall (sclk_fall)
    );

    adc_ser_bitsel #(
        .MAG_W (MAG_W),
        .LOW_W (LOW_W),
        .WIDE_W(WIDE_W),
        .IDX_W (IDX_W)
    ) u_bitsel (
        .mag  (st_q.mag),
        .sgn  (st_q.sgn),
        .cfg  (st_q.cfg),
        .idx  (sel_idx),
        .bit_o(sel_bit),
        .total(word_len)
    );

    always_comb begin
        st_d    = st_q;
        sel_idx = cs_fall ? '0 : st_q.idx + 1'b1;
        if (cs_n) begin
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
            st_d.idx  = '0;
            if (res_load) begin
                st_d.mag        = res_mag;
                st_d.sgn        = res_sign;
                st_d.cfg.full   = cfg_full;
                st_d.cfg.wide   = cfg_wide;
                st_d.cfg.sgn_en = cfg_sign_en;
                st_d.cfg.lsb    = cfg_lsb_first;
            end
        end else if (cs_fall) begin
            st_d.oe   = 1'b1;
            st_d.idx  = '0;
            st_d.dout = sel_bit;
        end else if (sclk_fall) begin
            if (st_q.idx < word_len) st_d.idx = st_q.idx + 1'b1;
            st_d.dout = sel_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.dout;
    assign sdo_oe = st_q.oe;
endmodule

// File: rtl/adc_result_shifter_chk.sv
module adc_result_shifter_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             cs_fall,
    input logic             sclk_fall,
    input logic [IDX_W-1:0] idx_q,
    input logic [IDX_W-1:0] word_len
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!sdo_oe && !sdo);
        end
    end

    // R6
    cs_low_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> sdo_oe);

    // R9
    cs_high_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !sdo));

    // R9
    restart_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (idx_q == '0));

    // R7
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !cs_fall && !sclk_fall) |=> $stable(sdo));

    // R8
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && idx_q >= word_len) |-> !sdo);
endmodule

bind adc_result_shifter adc_result_shifter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .idx_q    (st_q.idx),
    .word_len (word_len)
);

// File: tb/adc_result_shifter_test.sv
module adc_result_shifter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic res_load = 1'b0;
    logic [11:0] res_mag = '0;
    logic res_sign = 1'b0;
    logic cfg_full = 1'b0, cfg_wide = 1'b0, cfg_sign_en = 1'b0, cfg_lsb_first = 1'b0;
    logic sdo, sdo_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_result_shifter uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .res_load(res_load),
        .res_mag(res_mag), .res_sign(res_sign), .cfg_full(cfg_full), .cfg_wide(cfg_wide),
        .cfg_sign_en(cfg_sign_en), .cfg_lsb_first(cfg_lsb_first), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int word_len(input bit full, input bit wide, input bit sen);
        int w;
        w = full ? 12 : 8;
        return (wide ? 16 : w) + (sen ? 1 : 0);
    endfunction

    // Arithmetic model: word = {padding, magnitude}; order picks the end read first.
    function automatic logic exp_bit(input bit full, input bit wide, input bit sen, input bit lsb,
                                     input logic [11:0] mag, input bit sgn, input int k);
        int w, tot, ext;
        longint word;
        w    = full ? 12 : 8;
        tot  = word_len(full, wide, sen);
        ext  = tot - w;
        word = full ? longint'(mag) : longint'(mag >> 4);
        if (sen && sgn) word = word + (((longint'(1) << ext) - 1) << w);
        if (k >= tot) return 1'b0;
        if (lsb) return logic'((word >> k) & 1);
        return logic'((word >> (tot - 1 - k)) & 1);
    endfunction

    task automatic load(input logic [11:0] m, input bit s, input bit f, input bit w,
                        input bit se, input bit l);
        res_mag = m; res_sign = s; cfg_full = f; cfg_wide = w;
        cfg_sign_en = se; cfg_lsb_first = l; res_load = 1'b1;
        @(negedge clk);
        res_load = 1'b0;
    endtask

    task automatic cs_go_low();
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_go_high();
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic shift_one(input logic prev);
        sclk = 1'b1;
        @(negedge clk);
        chk("R7 hold on rising sclk", sdo, prev);
        @(negedge clk);
        chk("R7 hold while sclk high", sdo, prev);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_word(input logic [11:0] m, input bit s, input bit f, input bit w,
                            input bit se, input bit l);
        int tot;
        logic e, prev;
        string tag;
        tag = l ? "R5" : "R4";
        tot = word_len(f, w, se);
        load(m, s, f, w, se, l);
        cs_go_low();
        chk("R6 enable after cs fall", sdo_oe, 1'b1);
        e = exp_bit(f, w, se, l, m, s, 0);
        chk("R6 first bit", sdo, e);
        prev = e;
        for (int k = 1; k < tot; k++) begin
            shift_one(prev);
            e = exp_bit(f, w, se, l, m, s, k);
            chk(tag, sdo, e);
            prev = e;
        end
        // R3: one more fall must leave the word (length check)
        shift_one(prev);
        chk("R3 word ends at programmed length", sdo, 1'b0);
        shift_one(1'b0);
        chk("R8 zero after word", sdo, 1'b0);
        chk("R8 still driven", sdo_oe, 1'b1);
        cs_go_high();
        chk("R9 released", sdo_oe, 1'b0);
        chk("R9 data zero when released", sdo, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] pats[3];
        bit          sgns[3];
        pats[0] = 12'hA5C; sgns[0] = 1'b1;
        pats[1] = 12'h3B1; sgns[1] = 1'b0;
        pats[2] = 12'h8F7; sgns[2] = 1'b1;

        @(negedge clk);
        chk("R1 oe in reset", sdo_oe, 1'b0);
        chk("R1 sdo in reset", sdo, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", sdo_oe, 1'b0);
        chk("R1 sdo after reset", sdo, 1'b0);

        // R2 R3 R4 R5: every format combination with several data patterns
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 3; p++) begin
                run_word(pats[p], sgns[p], c[0], c[1], c[2], c[3]);
            end
        end

        // R9: abandon mid-word, then restart from the first bit
        begin
            logic e;
            load(12'hC3A, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            cs_go_low();
            e = exp_bit(1, 1, 1, 0, 12'hC3A, 1, 0);
            for (int k = 1; k < 8; k++) begin
                shift_one(e);
                e = exp_bit(1, 1, 1, 0, 12'hC3A, 1, k);
                chk("R9 pre-abandon bit", sdo, e);
            end
            cs_go_high();
            chk("R9 abandon releases", sdo_oe, 1'b0);
            cs_go_low();
            chk("R9 restart first bit", sdo, exp_bit(1, 1, 1, 0, 12'hC3A, 1, 0));
            cs_go_high();
        end

        // R10: a load while selected is ignored; R2: the earlier capture stays
        begin
            logic e;
            load(12'h0F0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
            cs_go_low();
            chk("R2 captured first bit", sdo, exp_bit(1, 0, 0, 1, 12'h0F0, 0, 0));
            load(12'hFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
            e = exp_bit(1, 0, 0, 1, 12'h0F0, 0, 0);
            for (int k = 1; k < 12; k++) begin
                shift_one(e);
                e = exp_bit(1, 0, 0, 1, 12'h0F0, 0, k);
                chk("R10 load ignored while selected", sdo, e);
            end
            shift_one(e);
            chk("R10 original length kept", sdo, 1'b0);
            cs_go_high();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule